// File: doc/BRIEF.md
# Pulse-Width Infrared Frame Decoder

This block turns the output of an infrared receiver head into a validated address and command pair. The receiver inverts the optical signal, so the line rests high and every burst of light shows as a low phase. The decoder runs on the system clock. A divided tick enable times each low and each high phase of the line, and a state machine accepts a frame only when every phase falls inside its tolerance window.

A frame opens with a long low leader and a shorter high gap. It then carries 32 bits, each a short low mark followed by a high space whose length gives the bit value. A trailing mark closes the last space. The four bytes must pass two complement checks and an address filter. Only then does the block present command and address on one 16-bit word, with a strobe lasting one clock. Partial, malformed or stalled frames drop the machine back to idle, and the output keeps its previous value.

States: `ST_IDLE` (wait for a falling edge), `ST_LEAD_LOW` (time the leader low), `ST_LEAD_HIGH` (time the leader gap), `ST_MARK` (time a bit mark), `ST_SPACE` (time a bit space and shift the bit in), `ST_CHECK` (one-cycle validation). Transitions: IDLE→LEAD_LOW on a falling edge. LEAD_LOW→LEAD_HIGH on a rising edge inside the leader-low window. LEAD_HIGH→MARK on a falling edge inside the gap window. MARK→SPACE on a rising edge inside the mark window. SPACE→MARK on a falling edge that ends a valid 0 or 1 space, for bits 1 to 31. SPACE→CHECK on the falling edge that ends bit 32. CHECK→IDLE always. Any window miss or timeout sends a state other than IDLE to IDLE.

Top module: `ir_frame_decoder`

## Requirements
- R1: After reset the strobe `frame_valid_o` is 0 and `frame_data_o` is 16'h0000.
- R2: A frame starts only after a low phase of 72 to 109 ticks followed by a high phase of 36 to 55 ticks. A leader low outside its window yields no strobe, and the output word is unchanged. One tick is CLK_DIV clock cycles.
- R3: Each bit is a low mark of 4 to 8 ticks. The high space that follows is a 0 if it lasts 4 to 8 ticks and a 1 if it lasts 13 to 21 ticks. The falling edge ending the 32nd space completes the frame.
- R4: Bits arrive least significant first, in four bytes in this order: address, inverted address, command, inverted command. On a good frame `frame_data_o[15:8]` holds the command and `frame_data_o[7:0]` holds the address. `frame_valid_o` is high for exactly one clock.
- R5: If the fourth byte is not the bitwise complement of the command, no strobe is given and `frame_data_o` holds its previous value.
- R6: If the second byte is not the bitwise complement of the address, no strobe is given and `frame_data_o` holds its previous value.
- R7: A frame whose address differs from parameter LOCAL_ADDR gives no strobe and leaves `frame_data_o` unchanged.
- R8: If any phase inside a frame reaches 120 ticks, the machine returns to idle at once. A leader that starts immediately afterwards is decoded.
- R9: A space whose width is in neither bit window aborts the frame. A later well-formed frame is still decoded.
- R10: Nominal widths distorted by about 20% in either direction (mark 5 and space 5 or 20 ticks, leader 74/40 ticks) are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n_i | input | 1 | Receiver-head output, idles high, asynchronous |
| frame_data_o | output | 16 | Command in [15:8], address in [7:0], held until the next good frame |
| frame_valid_o | output | 1 | One-clock strobe marking a new good frame |

## Verification
A line edge and a tick can land in the same clock. In that cycle the counter clears and that tick is lost, so every measured width is one tick below or at its nominal value. The bench provokes this by driving widths at the edges of the tolerance windows, with tick phases left unaligned. It judges the case by whether those frames are still accepted. A second collision, a timeout and an edge in the same region, is provoked by a stalled space followed at once by a new leader. It is judged by whether that next frame is decoded.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_LOW,
        ST_LEAD_HIGH,
        ST_MARK,
        ST_SPACE,
        ST_CHECK
    } ir_state_e;
endpackage

// File: rtl/ir_line_sync.sv
module ir_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_n_i,
    output logic fall_o,
    output logic rise_o
);
    logic [2:0] pipe;   // two synchroniser stages plus one history stage

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= 3'b111;
        else        pipe <= {pipe[1:0], ir_n_i};
    end

    assign fall_o = pipe[2] & ~pipe[1];
    assign rise_o = ~pipe[2] & pipe[1];
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int CLK_DIV = 2500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(CLK_DIV - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);

    generate
        if (CLK_DIV > 1) begin : g_chk
            // R2: widths are counted in ticks that never come back to back
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/ir_width_meter.sv
module ir_width_meter #(
    parameter int LIMIT = 120
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         clr_i,
    output logic [$clog2(LIMIT+1)-1:0]   cnt_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_o <= '0;
        else if (clr_i)                cnt_o <= '0;
        else if (tick_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder
    import ir_dec_pkg::*;
#(
    parameter int          CLK_DIV     = 2500,
    parameter logic [7:0]  LOCAL_ADDR  = 8'h00,
    parameter int          LEAD_LOW_T  = 90,
    parameter int          LEAD_HIGH_T = 45,
    parameter int          MARK_T      = 6,
    parameter int          ZERO_T      = 6,
    parameter int          ONE_T       = 17,
    parameter int          TIMEOUT_T   = 120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_n_i,
    output logic [15:0] frame_data_o,
    output logic        frame_valid_o
);
    localparam int FRAME_BITS = 32;
    localparam int BCW = $clog2(FRAME_BITS);
    localparam int CW  = $clog2(TIMEOUT_T + 1);
    // tolerance windows: -20% .. +20% rounded outward
    localparam logic [CW-1:0] LL_MIN = CW'(LEAD_LOW_T * 8 / 10);
    localparam logic [CW-1:0] LL_MAX = CW'(LEAD_LOW_T * 12 / 10 + 1);
    localparam logic [CW-1:0] LH_MIN = CW'(LEAD_HIGH_T * 8 / 10);
    localparam logic [CW-1:0] LH_MAX = CW'(LEAD_HIGH_T * 12 / 10 + 1);
    localparam logic [CW-1:0] MK_MIN = CW'(MARK_T * 8 / 10);
    localparam logic [CW-1:0] MK_MAX = CW'(MARK_T * 12 / 10 + 1);
    localparam logic [CW-1:0] B0_MIN = CW'(ZERO_T * 8 / 10);
    localparam logic [CW-1:0] B0_MAX = CW'(ZERO_T * 12 / 10 + 1);
    localparam logic [CW-1:0] B1_MIN = CW'(ONE_T * 8 / 10);
    localparam logic [CW-1:0] B1_MAX = CW'(ONE_T * 12 / 10 + 1);
    localparam logic [CW-1:0] TMO    = CW'(TIMEOUT_T);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

    logic          fall, rise, tick;
    logic [CW-1:0] width;
    ir_state_e     state, nxt;
    logic [31:0]   shreg;
    logic [BCW-1:0] bit_cnt;

    ir_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ir_n_i(ir_n_i), .fall_o(fall), .rise_o(rise)
    );

    ir_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ir_width_meter #(.LIMIT(TIMEOUT_T)) u_meter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(fall | rise), .cnt_o(width)
    );

    function automatic logic in_win(input logic [CW-1:0] v,
                                    input logic [CW-1:0] lo,
                                    input logic [CW-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    logic timeout, is_zero, is_one;
    assign timeout = (width >= TMO);
    assign is_zero = in_win(width, B0_MIN, B0_MAX);
    assign is_one  = in_win(width, B1_MIN, B1_MAX);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (fall) nxt = ST_LEAD_LOW;
            ST_LEAD_LOW:  if (timeout) nxt = ST_IDLE;
                          else if (rise) nxt = in_win(width, LL_MIN, LL_MAX) ? ST_LEAD_HIGH : ST_IDLE;
            ST_LEAD_HIGH: if (timeout) nxt = ST_IDLE;
                          else if (fall) nxt = in_win(width, LH_MIN, LH_MAX) ? ST_MARK : ST_IDLE;
            ST_MARK:      if (timeout) nxt = ST_IDLE;
                          else if (rise) nxt = in_win(width, MK_MIN, MK_MAX) ? ST_SPACE : ST_IDLE;
            ST_SPACE:     if (timeout) nxt = ST_IDLE;
                          else if (fall) begin
                              if (!(is_zero || is_one)) nxt = ST_IDLE;
                              else if (bit_cnt == LAST_BIT) nxt = ST_CHECK;
                              else nxt = ST_MARK;
                          end
            ST_CHECK:     nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit assembly, LSB first: byte0 addr, byte1 ~addr, byte2 cmd, byte3 ~cmd
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == ST_IDLE) begin
            bit_cnt <= '0;
        end else if (state == ST_SPACE && fall && !timeout && (is_zero || is_one)) begin
            shreg   <= {is_one, shreg[31:1]};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    logic frame_ok;
    assign frame_ok = (shreg[15:8]  == ~shreg[7:0])
                   && (shreg[31:24] == ~shreg[23:16])
                   && (shreg[7:0]   == LOCAL_ADDR);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_data_o  <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= 1'b0;
            if (state == ST_CHECK && frame_ok) begin
                frame_data_o  <= {shreg[23:16], shreg[7:0]};
                frame_valid_o <= 1'b1;
            end
        end
    end

    // R4: strobe lasts exactly one clock
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);
    // R4: a strobe only follows the validation state
    a_r4_strobe_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> $past(state) == ST_CHECK);
    // R5/R6: without a strobe the word does not move
    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> $stable(frame_data_o));
    // R7: only the local address is ever presented
    a_r7_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> frame_data_o[7:0] == LOCAL_ADDR);
    // R8: a saturated phase counter ends any frame in progress
    a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && width >= TMO) |=> state == ST_IDLE);
endmodule

// File: tb/sim_ir_frame_decoder.sv
module sim_ir_frame_decoder;
    localparam int DIV = 4;
    localparam logic [7:0] ADDR = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_n = 1'b1;
    logic [15:0] frame_data_o;
    logic        frame_valid_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] data;
        string       req;
    } exp_t;
    exp_t sb[$];
    logic [15:0] last_good = 16'h0000;

    always #2 clk = ~clk;   // 250 MHz

    ir_frame_decoder #(.CLK_DIV(DIV), .LOCAL_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_n_i(ir_n),
        .frame_data_o(frame_data_o), .frame_valid_o(frame_valid_o)
    );

    // monitor: pop and compare on every strobe
    always @(negedge clk) begin
        if (rst_n && frame_valid_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected strobe: actual %h expected none", frame_data_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (frame_data_o !== e.data) begin
                    fails++;
                    $display("FAIL %s word: actual %h expected %h", e.req, frame_data_o, e.data);
                end
            end
        end
    end

    task automatic hold(input logic lvl, input int ticks);
        ir_n = lvl;
        repeat (ticks * DIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] ai,
                              input logic [7:0] c, input logic [7:0] ci,
                              input int ll, input int lh, input int mk,
                              input int zs, input int os,
                              input bit good, input string req);
        logic [31:0] w;
        exp_t e;
        w = {ci, c, ai, a};
        if (good) begin
            e.data = {c, a};
            e.req  = req;
            sb.push_back(e);
            last_good = {c, a};
        end
        hold(0, ll);
        hold(1, lh);
        for (int i = 0; i < 32; i++) begin
            hold(0, mk);
            hold(1, w[i] ? os : zs);
        end
        hold(0, mk);       // trailing mark
        hold(1, 30);
    endtask

    task automatic nominal(input logic [7:0] a, input logic [7:0] c,
                           input bit good, input string req);
        send_frame(a, ~a, c, ~c, 90, 45, 6, 6, 17, good, req);
    endtask

    task automatic check_word(input string req);
        checks++;
        if (frame_data_o !== last_good) begin
            fails++;
            $display("FAIL %s held word: actual %h expected %h", req, frame_data_o, last_good);
        end
    endtask

    task automatic check_drained(input string req);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s missing strobe: actual %0d pending expected 0", req, sb.size());
            sb.delete();
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        checks++;
        if (frame_valid_o !== 1'b0) begin
            fails++; $display("FAIL R1 strobe: actual %b expected 0", frame_valid_o);
        end
        checks++;
        if (frame_data_o !== 16'h0000) begin
            fails++; $display("FAIL R1 word: actual %h expected 0000", frame_data_o);
        end
        rst_n = 1'b1;
        hold(1, 20);

        // R3 R4: several command patterns
        nominal(ADDR, 8'h3C, 1, "R3");  check_drained("R3"); check_word("R4");
        nominal(ADDR, 8'hA5, 1, "R4");  check_drained("R4");
        nominal(ADDR, 8'h00, 1, "R3");  check_drained("R3");
        nominal(ADDR, 8'hFF, 1, "R4");  check_drained("R4"); check_word("R4");

        // R5: command complement broken
        send_frame(ADDR, ~ADDR, 8'h12, 8'hED ^ 8'h01, 90, 45, 6, 6, 17, 0, "R5");
        check_drained("R5"); check_word("R5");

        // R6: address complement broken
        send_frame(ADDR, ~ADDR ^ 8'h80, 8'h34, 8'hCB, 90, 45, 6, 6, 17, 0, "R6");
        check_drained("R6"); check_word("R6");

        // R7: foreign address
        nominal(8'h33, 8'h77, 0, "R7");
        check_drained("R7"); check_word("R7");

        // R10: widths at the edges of the tolerance windows
        send_frame(ADDR, ~ADDR, 8'h69, 8'h96, 74, 40, 5, 5, 20, 1, "R10");
        check_drained("R10"); check_word("R10");

        // R2: leader low too short
        send_frame(ADDR, ~ADDR, 8'h21, 8'hDE, 60, 45, 6, 6, 17, 0, "R2");
        hold(1, 20);
        check_drained("R2"); check_word("R2");

        // R9: invalid space width in the middle of a frame
        hold(0, 90); hold(1, 45);
        for (int i = 0; i < 5; i++) begin hold(0, 6); hold(1, 6); end
        hold(0, 6); hold(1, 10);
        hold(0, 6); hold(1, 30);
        nominal(ADDR, 8'h4E, 1, "R9");
        check_drained("R9"); check_word("R9");

        // R8: stalled space, new leader right after the timeout
        hold(0, 90); hold(1, 45);
        for (int i = 0; i < 10; i++) begin hold(0, 6); hold(1, 17); end
        hold(0, 6); hold(1, 150);
        nominal(ADDR, 8'hC3, 1, "R8");
        check_drained("R8"); check_word("R8");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule